// File: doc/BRIEF.md
# Feedback-Chained Four-Rail Power Sequencer

This block switches a set of supply rails on and off in a fixed order. It does not use timers between the rails. Each rail switch is enabled only after the rail before it reports that its gate drive is close to full level. When the block is disabled, the rails are released in the opposite order. Each release waits for the rail above it to report that its gate has fallen below the low threshold. Per-rail comparator flags stand in for the analog measurements. The block only looks at these flags and never models a ramp.

Start-up needs three things to hold together for a qualification window: every rail's undervoltage-ok flag (after a glitch filter), an active enable, and no external kill. At the end of the window, channel A (bit 0) is switched on. Once the last channel reports full gate, a settle counter runs, and then the active-low ready output is released. If a filtered undervoltage loss occurs while any rail is being driven, all switches drop in the same cycle, ready goes low and the kill output is pulled low. The block restarts on its own once every flag is valid again. A feedback that never arrives stalls the sequence and raises a stall flag until the feedback shows up.

Top module: `rail_chain_seq`

## Requirements
- R1: While reset is held and on the first cycle after it, `sw_en` is all zero, `rdy_n` is 0, `kill_out_n` is 1 and `stall` is 0.
- R2: `sw_en[0]` rises QUAL_CYC+1 cycles after `en_n` goes low, provided the filtered undervoltage flags are all 1 and `kill_in_n` is 1 for that whole time. Any break in these conditions restarts the count, and no switch is enabled.
- R3: Switches turn on in bit order, with channel A at bit 0. `sw_en[k+1]` rises one cycle after `gate_hi[k]` is seen high while channel k is the one being waited on. `sw_en` is always a thermometer code.
- R4: `rdy_n` goes high RST_CYC+1 cycles after `gate_hi[NCH-1]` is seen. It is high only while every switch is on.
- R5: `en_n` going high while all rails are on drops `rdy_n` and `sw_en[NCH-1]` one cycle later. After that, `sw_en[k-1]` drops one cycle after `gate_lo[k]` is seen high.
- R6: An undervoltage flag that is low for fewer than FILT_CYC consecutive cycles has no effect on any output.
- R7: An undervoltage flag that is low for FILT_CYC cycles while a rail is driven clears all of `sw_en` FILT_CYC+1 cycles after it first went low. In that same cycle `rdy_n` is forced to 0 and `kill_out_n` to 0. `kill_out_n` stays low until every filtered flag is 1 again.
- R8: After a fault, `kill_out_n` returns to 1 FILT_CYC+1 cycles after the last flag recovers. If enable is still active and the kill input is high, `sw_en[0]` rises QUAL_CYC+1 cycles after that.
- R9: `kill_in_n` low clears `sw_en` and `rdy_n` one cycle later and holds them clear while it stays low. When it goes high again, qualification starts over.
- R10: If the awaited feedback is missing for TMO_CYC cycles after a step, `stall` goes to 1 and the switches hold. When the feedback arrives, the sequence advances and `stall` returns to 0 in the same cycle.
- R11: Disabling partway through the turn-on drops only the highest enabled switch first. The rest of the turn-off then follows R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uv_ok | input | NCH | Raw undervoltage-ok flag per rail (1 = rail above threshold) |
| en_n | input | 1 | Active-low sequence enable |
| gate_hi | input | NCH | Per-rail gate-near-full feedback |
| gate_lo | input | NCH | Per-rail gate-below-low-threshold feedback |
| kill_in_n | input | 1 | Active-low unconditional shut-off request |
| sw_en | output | NCH | Rail switch enables, bit 0 = channel A |
| rdy_n | output | 1 | Active-low reset output, high once all rails are settled |
| kill_out_n | output | 1 | Active-low kill output, low while an undervoltage fault persists |
| stall | output | 1 | Feedback timeout indicator |

## Verification
Every result has a fixed delay after the stimulus that causes it:
- one cycle for a feedback step, an enable removal or the kill input;
- FILT_CYC+1 cycles for a filtered undervoltage loss;
- QUAL_CYC+1 cycles from enable to the first switch;
- RST_CYC+1 cycles from the last full-gate report to ready;
- TMO_CYC cycles from a step to the stall flag.

The driver pushes each expected output tuple together with the absolute cycle at which it is due. The monitor samples a quarter period after each rising edge. It pops an entry only when the outputs actually change, so any change that comes early, late or unannounced is a miscompare. The glitch, held-off and interrupted-qualification cases are checked directly once their window has passed.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_QUAL,
      ST_RISE,
      ST_SETTLE,
      ST_ON,
      ST_FALL,
      ST_FAULT
   } rcs_state_e;
endpackage

// File: rtl/rcs_glitch_filt.sv
module rcs_glitch_filt #(
   parameter int FILT_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   output logic filt_o
);
   generate
      if (FILT_CYC < 1) begin : g_bad
         $error("rcs_glitch_filt: FILT_CYC must be at least 1");
      end
      if (FILT_CYC == 1) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) filt_o <= 1'b0;
            else        filt_o <= raw_i;
         end
      end else begin : g_count
         localparam int CW = $clog2(FILT_CYC);
         localparam logic [CW-1:0] LAST_V = CW'(FILT_CYC - 1);
         logic [CW-1:0] run_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run_q  <= '0;
               filt_o <= 1'b0;
            end else if (raw_i == filt_o) begin
               run_q <= '0;
            end else if (run_q == LAST_V) begin
               run_q  <= '0;
               filt_o <= raw_i;
            end else begin
               run_q <= run_q + 1'b1;
            end
         end
      end
   endgenerate

   // R6
   filt_follows_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(filt_o) |-> ($past(raw_i) == filt_o));
endmodule

// File: rtl/rcs_span_cnt.sv
module rcs_span_cnt #(
   parameter int LIMIT = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic run_i,
   output logic done_o
);
   localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
   localparam logic [CW-1:0] LAST_V = CW'(LIMIT - 1);

   generate
      if (LIMIT < 1) begin : g_bad
         $error("rcs_span_cnt: LIMIT must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   assign done_o = (cnt_q == LAST_V);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt_q <= '0;
      else if (clr_i)             cnt_q <= '0;
      else if (run_i && !done_o)  cnt_q <= cnt_q + 1'b1;
   end

   // R10
   span_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(done_o) && !$past(clr_i)) |-> done_o);
endmodule

// File: rtl/rail_chain_seq.sv
module rail_chain_seq #(
   parameter int NCH      = 4,
   parameter int FILT_CYC = 1500,
   parameter int QUAL_CYC = 500000,
   parameter int RST_CYC  = 8000000,
   parameter int TMO_CYC  = 50000
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] uv_ok,
   input  logic           en_n,
   input  logic [NCH-1:0] gate_hi,
   input  logic [NCH-1:0] gate_lo,
   input  logic           kill_in_n,
   output logic [NCH-1:0] sw_en,
   output logic           rdy_n,
   output logic           kill_out_n,
   output logic           stall
);
   import rcs_pkg::*;

   localparam int IW = $clog2(NCH);
   localparam logic [IW-1:0] LAST_IDX = IW'(NCH - 1);
   localparam logic [NCH-1:0] ONE_V = NCH'(1);

   generate
      if (NCH < 2) begin : g_bad_nch
         $error("rail_chain_seq: NCH must be at least 2");
      end
   endgenerate

   logic [NCH-1:0] uv_f;
   genvar gi;
   generate
      for (gi = 0; gi < NCH; gi++) begin : g_filt
         rcs_glitch_filt #(.FILT_CYC(FILT_CYC)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (uv_ok[gi]),
            .filt_o (uv_f[gi])
         );
      end
   endgenerate

   rcs_state_e     st_q;
   logic [NCH-1:0] sw_q;
   logic [IW-1:0]  idx_q;
   logic           rdy_q, kill_q, stall_q;

   logic all_ok, go, driving, waiting, step, qual_done, settle_done, tmo_done;

   assign all_ok  = &uv_f;
   assign go      = all_ok && !en_n && kill_in_n;
   assign driving = (st_q == ST_RISE) || (st_q == ST_SETTLE) ||
                    (st_q == ST_ON)   || (st_q == ST_FALL);
   assign waiting = (st_q == ST_RISE) || (st_q == ST_FALL);
   assign step    = ((st_q == ST_RISE) && !en_n && gate_hi[idx_q]) ||
                    ((st_q == ST_FALL) && gate_lo[idx_q]);

   rcs_span_cnt #(.LIMIT(QUAL_CYC)) u_qual (
      .clk(clk), .rst_n(rst_n),
      .clr_i(st_q != ST_QUAL), .run_i(1'b1), .done_o(qual_done));

   rcs_span_cnt #(.LIMIT(RST_CYC)) u_settle (
      .clk(clk), .rst_n(rst_n),
      .clr_i(st_q != ST_SETTLE), .run_i(1'b1), .done_o(settle_done));

   rcs_span_cnt #(.LIMIT(TMO_CYC)) u_tmo (
      .clk(clk), .rst_n(rst_n),
      .clr_i(!waiting || step || ((st_q == ST_RISE) && en_n)),
      .run_i(1'b1), .done_o(tmo_done));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         sw_q    <= '0;
         idx_q   <= '0;
         rdy_q   <= 1'b0;
         kill_q  <= 1'b1;
         stall_q <= 1'b0;
      end else if (driving && !all_ok) begin
         st_q    <= ST_FAULT;
         sw_q    <= '0;
         rdy_q   <= 1'b0;
         kill_q  <= 1'b0;
         stall_q <= 1'b0;
      end else if (!kill_in_n && (st_q != ST_FAULT)) begin
         st_q    <= ST_IDLE;
         sw_q    <= '0;
         rdy_q   <= 1'b0;
         stall_q <= 1'b0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (go) st_q <= ST_QUAL;
            end
            ST_QUAL: begin
               if (!go) begin
                  st_q <= ST_IDLE;
               end else if (qual_done) begin
                  st_q  <= ST_RISE;
                  idx_q <= '0;
                  sw_q  <= ONE_V;
               end
            end
            ST_RISE: begin
               if (en_n) begin
                  st_q        <= ST_FALL;
                  sw_q[idx_q] <= 1'b0;
                  stall_q     <= 1'b0;
               end else if (gate_hi[idx_q]) begin
                  stall_q <= 1'b0;
                  if (idx_q == LAST_IDX) begin
                     st_q <= ST_SETTLE;
                  end else begin
                     idx_q               <= idx_q + 1'b1;
                     sw_q[idx_q + 1'b1]  <= 1'b1;
                  end
               end else if (tmo_done) begin
                  stall_q <= 1'b1;
               end
            end
            ST_SETTLE: begin
               if (en_n) begin
                  st_q           <= ST_FALL;
                  sw_q[LAST_IDX] <= 1'b0;
                  idx_q          <= LAST_IDX;
               end else if (settle_done) begin
                  st_q  <= ST_ON;
                  rdy_q <= 1'b1;
               end
            end
            ST_ON: begin
               if (en_n) begin
                  st_q           <= ST_FALL;
                  sw_q[LAST_IDX] <= 1'b0;
                  idx_q          <= LAST_IDX;
                  rdy_q          <= 1'b0;
               end
            end
            ST_FALL: begin
               if (gate_lo[idx_q]) begin
                  stall_q <= 1'b0;
                  if (idx_q == '0) begin
                     st_q <= ST_IDLE;
                  end else begin
                     idx_q              <= idx_q - 1'b1;
                     sw_q[idx_q - 1'b1] <= 1'b0;
                  end
               end else if (tmo_done) begin
                  stall_q <= 1'b1;
               end
            end
            ST_FAULT: begin
               if (all_ok) begin
                  st_q   <= ST_IDLE;
                  kill_q <= 1'b1;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign sw_en      = sw_q;
   assign rdy_n      = rdy_q;
   assign kill_out_n = kill_q;
   assign stall      = stall_q;

   // R3
   sw_thermo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((sw_q & (sw_q + ONE_V)) == '0));

   // R4
   rdy_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rdy_q |-> (&sw_q));

   // R7
   kill_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !kill_q |-> (sw_q == '0));

   // R9
   kill_in_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(kill_in_n) |-> ((sw_q == '0) && !rdy_q));

   generate
      for (gi = 1; gi < NCH; gi++) begin : g_order_chk
         // R3
         rise_after_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(sw_q[gi]) |-> $past(gate_hi[gi-1]));
      end
   endgenerate
endmodule

// File: tb/rail_chain_seq_tb_top.sv
module rail_chain_seq_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NCH  = 4;
   localparam int FILT = 3;
   localparam int QUAL = 8;
   localparam int RSTC = 6;
   localparam int TMO  = 12;

   typedef struct {
      logic [3:0] sw;
      logic       rdy;
      logic       kill;
      logic       stl;
      int         at;
      string      req;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NCH-1:0] uv_ok = '0;
   logic en_n = 1'b1;
   logic [NCH-1:0] gate_hi = '0;
   logic [NCH-1:0] gate_lo = '1;
   logic kill_in_n = 1'b1;
   logic [NCH-1:0] sw_en;
   logic rdy_n, kill_out_n, stall;

   int cyc = 0;
   int n_vec = 0;
   int n_bad = 0;
   bit mon_on = 1'b0;
   bit done = 1'b0;
   exp_t exp_q[$];

   rail_chain_seq #(.NCH(NCH), .FILT_CYC(FILT), .QUAL_CYC(QUAL),
                    .RST_CYC(RSTC), .TMO_CYC(TMO)) dut_i (
      .clk(clk), .rst_n(rst_n), .uv_ok(uv_ok), .en_n(en_n),
      .gate_hi(gate_hi), .gate_lo(gate_lo), .kill_in_n(kill_in_n),
      .sw_en(sw_en), .rdy_n(rdy_n), .kill_out_n(kill_out_n), .stall(stall));

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [3:0] thermo(input int k);
      return 4'((1 << k) - 1);
   endfunction

   task automatic push(input logic [3:0] sw, input logic r, input logic k,
                       input logic s, input int lat, input string req);
      exp_t e;
      e.sw = sw; e.rdy = r; e.kill = k; e.stl = s; e.at = cyc + lat; e.req = req;
      exp_q.push_back(e);
   endtask

   task automatic wait_until(input int t);
      while (cyc < t) @(negedge clk);
   endtask

   task automatic drain();
      if (exp_q.size() > 0) wait_until(exp_q[$].at);
   endtask

   task automatic check(input bit ok, input string req, input logic [6:0] act,
                        input logic [6:0] expv);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b at cycle %0d", req, act, expv, cyc);
      end
   endtask

   // scoreboard monitor: every output change must match the head of the queue
   logic [6:0] prev_o;
   always @(posedge clk) begin
      #(CLK_PERIOD/4);
      if (mon_on) begin
         logic [6:0] cur;
         cur = {sw_en, rdy_n, kill_out_n, stall};
         if (cur !== prev_o) begin
            if (exp_q.size() == 0) begin
               n_vec++; n_bad++;
               $display("FAIL unexpected change: actual %b expected %b at cycle %0d",
                        cur, prev_o, cyc);
            end else begin
               exp_t e;
               logic [6:0] ev;
               e = exp_q.pop_front();
               ev = {e.sw, e.rdy, e.kill, e.stl};
               check((cur === ev) && (cyc == e.at), e.req, cur, ev);
               if (cyc != e.at)
                  $display("  due cycle %0d, seen cycle %0d", e.at, cyc);
            end
            prev_o = cur;
         end
      end
   end

   task automatic ramp_up(input int i);
      @(negedge clk) gate_lo[i] = 1'b0;
      @(negedge clk);
      if (i < NCH-1) push(thermo(i+2), 1'b0, 1'b1, 1'b0, 1, "R3");
      else           push(4'b1111, 1'b1, 1'b1, 1'b0, 1 + RSTC, "R4");
      gate_hi[i] = 1'b1;
      drain();
   endtask

   task automatic ramp_down(input int i);
      @(negedge clk);
      gate_hi[i] = 1'b0;
      gate_lo[i] = 1'b1;
      if (i > 0) begin
         push(thermo(i-1), 1'b0, 1'b1, 1'b0, 1, "R5");
         drain();
      end else begin
         repeat (2) @(negedge clk);
      end
   endtask

   task automatic plant_off();
      gate_hi = '0;
      gate_lo = '1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state while held
      check({sw_en, rdy_n, kill_out_n, stall} === 7'b0000_010, "R1",
            {sw_en, rdy_n, kill_out_n, stall}, 7'b0000_010);
      rst_n = 1'b1;
      @(negedge clk);
      check({sw_en, rdy_n, kill_out_n, stall} === 7'b0000_010, "R1",
            {sw_en, rdy_n, kill_out_n, stall}, 7'b0000_010);
      prev_o = {sw_en, rdy_n, kill_out_n, stall};
      mon_on = 1'b1;

      // R2: interrupted qualification enables nothing
      uv_ok = '1; en_n = 1'b0;
      repeat (FILT + 3) @(negedge clk);
      en_n = 1'b1;
      repeat (QUAL) @(negedge clk);
      check(sw_en === 4'b0000, "R2", {sw_en, rdy_n, kill_out_n, stall}, 7'b0000_010);

      // R2/R3/R4: full chained turn-on
      en_n = 1'b0;
      push(4'b0001, 1'b0, 1'b1, 1'b0, 1 + QUAL, "R2");
      drain();
      for (int i = 0; i < NCH; i++) ramp_up(i);

      // R6: short undervoltage dip ignored
      @(negedge clk) uv_ok[2] = 1'b0;
      repeat (FILT - 1) @(negedge clk);
      uv_ok[2] = 1'b1;
      repeat (8) @(negedge clk);
      check({sw_en, rdy_n, kill_out_n} === 6'b1111_11, "R6",
            {sw_en, rdy_n, kill_out_n, stall}, 7'b1111_110);

      // R5: reverse turn-off
      en_n = 1'b1;
      push(4'b0111, 1'b0, 1'b1, 1'b0, 1, "R5");
      drain();
      for (int i = NCH-1; i >= 0; i--) ramp_down(i);

      // R11: disable partway up
      en_n = 1'b0;
      push(4'b0001, 1'b0, 1'b1, 1'b0, 1 + QUAL, "R2");
      drain();
      ramp_up(0);
      @(negedge clk) gate_lo[1] = 1'b0;
      @(negedge clk);
      en_n = 1'b1;
      push(4'b0001, 1'b0, 1'b1, 1'b0, 1, "R11");
      drain();
      ramp_down(1);
      ramp_down(0);

      // R10: missing feedback stalls, arrival resumes
      en_n = 1'b0;
      push(4'b0001, 1'b0, 1'b1, 1'b0, 1 + QUAL, "R2");
      drain();
      gate_lo[0] = 1'b0;
      push(4'b0001, 1'b0, 1'b1, 1'b1, TMO, "R10");
      drain();
      repeat (3) @(negedge clk);
      check(stall === 1'b1 && sw_en === 4'b0001, "R10",
            {sw_en, rdy_n, kill_out_n, stall}, 7'b0001_011);
      gate_hi[0] = 1'b1;
      push(4'b0011, 1'b0, 1'b1, 1'b0, 1, "R10");
      drain();
      for (int i = 1; i < NCH; i++) ramp_up(i);

      // R7/R8: undervoltage fault and automatic restart
      @(negedge clk) uv_ok[1] = 1'b0;
      push(4'b0000, 1'b0, 1'b0, 1'b0, FILT + 1, "R7");
      drain();
      plant_off();
      repeat (6) @(negedge clk);
      check(kill_out_n === 1'b0 && sw_en === 4'b0000, "R7",
            {sw_en, rdy_n, kill_out_n, stall}, 7'b0000_000);
      uv_ok[1] = 1'b1;
      push(4'b0000, 1'b0, 1'b1, 1'b0, FILT + 1, "R8");
      push(4'b0001, 1'b0, 1'b1, 1'b0, FILT + 2 + QUAL, "R8");
      drain();
      for (int i = 0; i < NCH; i++) ramp_up(i);

      // R9: kill input
      @(negedge clk) kill_in_n = 1'b0;
      push(4'b0000, 1'b0, 1'b1, 1'b0, 1, "R9");
      drain();
      plant_off();
      repeat (QUAL + 4) @(negedge clk);
      check(sw_en === 4'b0000 && rdy_n === 1'b0, "R9",
            {sw_en, rdy_n, kill_out_n, stall}, 7'b0000_010);
      kill_in_n = 1'b1;
      push(4'b0001, 1'b0, 1'b1, 1'b0, 1 + QUAL, "R9");
      drain();
      repeat (4) @(negedge clk);

      check(exp_q.size() == 0, "R3", 7'(exp_q.size()), 7'd0);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_vec++; n_bad++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule